// File: doc/BRIEF.md
# Chopped-Phase Sweep Sequencer

This block walks a frequency sweep one point at a time. For each point it fetches a 96-bit configuration word from a small external memory and takes the 12-bit fractional modulus from that word. It then runs a fixed number of measurement stages. For each stage it holds a busy flag until an external stage-done pulse arrives. Each completed stage produces a 16-bit result tag, so downstream accumulation can file the result in the right place.

When chopping is enabled, every point is measured twice. The first pass uses source phase zero. The second pass repeats all stages with the source phase set to half the modulus, which is a 180 degree offset. The configuration memory holds no per-point phase. The sequencer derives the offset itself, and it puts the pass bit in the lowest bit of each tag. Chopping is switched by one bit of a control register, written through a simple register-write port.

Top module: `sweep_sequencer`

## Requirements
- R1: A register write to address 6 sets the chop enable from data bit 11, starting on the cycle after the write. Writes to any other address, and the other data bits, have no effect on chopping.
- R2: On entering each point, `cfg_rd_en` is high for exactly one cycle with `cfg_rd_addr` equal to the point number. The memory returns the word on the following cycle, and the modulus is taken from bits [11:0] of that word.
- R3: `stage_count` (1 to 7) sets the number of stages per point, and 0 is treated as 1. `stage_busy` stays high while a stage waits for `stage_done`. A `stage_done` that arrives while `stage_busy` is low is ignored.
- R4: A `stage_done` accepted while busy produces, on the next cycle, a one-cycle `tag_valid` with `tag` = {stage[2:0], point[11:0], pass}. The stage number starts at 0.
- R5: With chopping enabled for a point, all stages run with pass 0 and then all run again with pass 1, before the next point starts.
- R6: During a stage, `src_modulus` equals the point's modulus M. `src_phase` is 0 in pass 0 and floor(M/2) in pass 1.
- R7: With chopping disabled for a point, the stages run once, and the pass bit and `src_phase` are 0.
- R8: The chop enable is sampled once, while the point's configuration read is issued. A change made later within the point does not split or add a pass.
- R9: Points run from 0 up to `sweep_last_point`, which is captured at start. `sweep_done` pulses together with the final tag, and the block then stays idle. A `sweep_start` that arrives during a sweep is ignored.
- R10: After reset the block is idle: no read, no busy, no tag, no done, pass 0, chopping disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 4 | Register write address |
| reg_wr_data | input | 16 | Register write data |
| sweep_start | input | 1 | Starts a sweep when idle |
| sweep_last_point | input | 12 | Index of the final point |
| stage_count | input | 3 | Stages per point (0 is treated as 1) |
| cfg_rd_en | output | 1 | Configuration memory read strobe |
| cfg_rd_addr | output | 12 | Configuration memory address (point number) |
| cfg_rd_data | input | 96 | Configuration word, valid one cycle after the read |
| src_modulus | output | 12 | Fractional modulus of the current point |
| src_phase | output | 12 | Source phase value for the current pass |
| chop_phase | output | 1 | Current pass bit |
| stage_busy | output | 1 | A stage is waiting for completion |
| stage_done | input | 1 | Stage completion pulse |
| tag_valid | output | 1 | Result tag strobe |
| tag | output | 16 | Result tag {stage, point, pass} |
| sweep_done | output | 1 | Pulses with the last tag of a sweep |

## Verification
A register write takes effect one cycle after its strobe. A sampled start raises the configuration read one cycle later, and `stage_busy` follows two cycles after that read. A tag, and `sweep_done` on the last stage, appear exactly one cycle after the accepted `stage_done`. The bench drives all inputs at the falling edge and compares outputs at the next falling edge. It processes a tag before a read that arrives in the same cycle. The bench keeps its own copy of the enable, updated in the cycle the register changes, and latches that copy when it observes each configuration read. This lets it predict the pass pairing even while random register writes land inside a point.

// File: rtl/sweep_seq_pkg.sv
package sweep_seq_pkg;
  localparam int POINT_W = 12;
  localparam int STAGE_W = 3;
  localparam int MOD_W   = 12;
  localparam int CFG_W   = 96;
  localparam int TAG_W   = STAGE_W + POINT_W + 1;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_CAPT, S_RUN} seq_state_t;

  // Offset for the second pass: half the modulus, rounded down.
  function automatic logic [MOD_W-1:0] half_modulus(input logic [MOD_W-1:0] m);
    return m >> 1;
  endfunction

  // A stage count of zero runs one stage.
  function automatic logic [STAGE_W-1:0] stages_eff(input logic [STAGE_W-1:0] n);
    return (n == '0) ? STAGE_W'(1) : n;
  endfunction

  function automatic logic [TAG_W-1:0] pack_tag(input logic [STAGE_W-1:0] st,
                                                input logic [POINT_W-1:0] pt,
                                                input logic ph);
    return {st, pt, ph};
  endfunction
endpackage

// File: rtl/sweep_ctrl_reg.sv
module sweep_ctrl_reg #(
  parameter int AW = 4,
  parameter int DW = 16,
  parameter int CTRL_ADDR = 6,
  parameter int CHOP_BIT = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          chop_en_o
);
  logic hit;
  assign hit = wr_en && (wr_addr == AW'(CTRL_ADDR));

  always_ff @(posedge clk) begin
    if (!rst_n)   chop_en_o <= 1'b0;
    else if (hit) chop_en_o <= wr_data[CHOP_BIT];
  end

  // R1: only a write to the control address may change the enable
  p_reg_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(chop_en_o));
endmodule

// File: rtl/sweep_phase_gen.sv
module sweep_phase_gen
  import sweep_seq_pkg::*;
(
  input  logic [MOD_W-1:0] modulus_i,
  input  logic             chop_phase_i,
  output logic [MOD_W-1:0] phase_o
);
  always_comb phase_o = chop_phase_i ? half_modulus(modulus_i) : '0;
endmodule

// File: rtl/sweep_fsm.sv
module sweep_fsm
  import sweep_seq_pkg::*;
#(
  parameter int MOD_LSB = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [POINT_W-1:0] last_point_i,
  input  logic [STAGE_W-1:0] num_stages_i,
  input  logic               chop_en_i,
  input  logic               stage_done_i,
  output logic               cfg_rd_o,
  output logic [POINT_W-1:0] cfg_addr_o,
  input  logic [CFG_W-1:0]   cfg_data_i,
  output logic [MOD_W-1:0]   modulus_o,
  output logic               chop_phase_o,
  output logic               busy_o,
  output logic               tag_valid_o,
  output logic [TAG_W-1:0]   tag_o,
  output logic               done_o,
  output logic               ev_stage_accept,
  output logic               ev_pass_flip,
  output logic               ev_point_end
);
  seq_state_t         state_q;
  logic [POINT_W-1:0] point_q, lastp_q;
  logic [STAGE_W-1:0] stage_q, stages_q;
  logic               chop_q, phase_q;
  logic [MOD_W-1:0]   mod_q;
  logic               last_stage, sweep_end;

  wire unused_cfg_bits = ^cfg_data_i;

  assign last_stage      = (stage_q == stages_q - STAGE_W'(1));
  assign ev_stage_accept = (state_q == S_RUN) && stage_done_i;
  assign ev_pass_flip    = ev_stage_accept && last_stage && chop_q && !phase_q;
  assign ev_point_end    = ev_stage_accept && last_stage && !ev_pass_flip;
  assign sweep_end       = ev_point_end && (point_q == lastp_q);

  assign cfg_rd_o     = (state_q == S_LOAD);
  assign cfg_addr_o   = point_q;
  assign busy_o       = (state_q == S_RUN);
  assign modulus_o    = mod_q;
  assign chop_phase_o = phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      point_q     <= '0;
      lastp_q     <= '0;
      stage_q     <= '0;
      stages_q    <= STAGE_W'(1);
      chop_q      <= 1'b0;
      phase_q     <= 1'b0;
      mod_q       <= '0;
      tag_valid_o <= 1'b0;
      tag_o       <= '0;
      done_o      <= 1'b0;
    end else begin
      tag_valid_o <= ev_stage_accept;
      done_o      <= sweep_end;
      if (ev_stage_accept) tag_o <= pack_tag(stage_q, point_q, phase_q);
      unique case (state_q)
        S_IDLE: if (start_i) begin
          point_q  <= '0;
          lastp_q  <= last_point_i;
          stages_q <= stages_eff(num_stages_i);
          state_q  <= S_LOAD;
        end
        S_LOAD: begin
          chop_q  <= chop_en_i;
          phase_q <= 1'b0;
          stage_q <= '0;
          state_q <= S_CAPT;
        end
        S_CAPT: begin
          mod_q   <= cfg_data_i[MOD_LSB +: MOD_W];
          state_q <= S_RUN;
        end
        S_RUN: if (ev_stage_accept) begin
          if (!last_stage) begin
            stage_q <= stage_q + STAGE_W'(1);
          end else if (ev_pass_flip) begin
            phase_q <= 1'b1;
            stage_q <= '0;
          end else if (sweep_end) begin
            phase_q <= 1'b0;
            state_q <= S_IDLE;
          end else begin
            point_q <= point_q + POINT_W'(1);
            state_q <= S_LOAD;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R2: the read lasts one cycle and is followed by the capture cycle
  p_read_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd_o |=> !cfg_rd_o && !busy_o);
  // R3: the stage index stays below the latched stage count
  p_stage_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> stage_q < stages_q);
  // R7: pass 1 exists only for points that latched the enable
  p_pass_needs_chop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q |-> chop_q);
  // R5: a pass flip restarts the stages of the same point in pass 1
  p_flip_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pass_flip |=> busy_o && phase_q && stage_q == '0 && $stable(point_q));
  // R9: done comes with a tag, and the block is idle by then
  p_done_with_tag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> tag_valid_o && !busy_o && !cfg_rd_o);
  // R4: a tag never appears without an accepted stage one cycle earlier
  p_tag_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tag_valid_o) |-> $past(busy_o));
endmodule

// File: rtl/sweep_sequencer.sv
module sweep_sequencer
  import sweep_seq_pkg::*;
#(
  parameter int REG_AW = 4,
  parameter int REG_DW = 16,
  parameter int CTRL_ADDR = 6,
  parameter int CHOP_BIT = 11,
  parameter int MOD_LSB = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr_en,
  input  logic [REG_AW-1:0]  reg_wr_addr,
  input  logic [REG_DW-1:0]  reg_wr_data,
  input  logic               sweep_start,
  input  logic [POINT_W-1:0] sweep_last_point,
  input  logic [STAGE_W-1:0] stage_count,
  output logic               cfg_rd_en,
  output logic [POINT_W-1:0] cfg_rd_addr,
  input  logic [CFG_W-1:0]   cfg_rd_data,
  output logic [MOD_W-1:0]   src_modulus,
  output logic [MOD_W-1:0]   src_phase,
  output logic               chop_phase,
  output logic               stage_busy,
  input  logic               stage_done,
  output logic               tag_valid,
  output logic [TAG_W-1:0]   tag,
  output logic               sweep_done
);
  logic chop_en;
  logic ev_stage_accept, ev_pass_flip, ev_point_end;

  sweep_ctrl_reg #(.AW(REG_AW), .DW(REG_DW), .CTRL_ADDR(CTRL_ADDR), .CHOP_BIT(CHOP_BIT)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_addr(reg_wr_addr),
    .wr_data(reg_wr_data), .chop_en_o(chop_en));

  sweep_fsm #(.MOD_LSB(MOD_LSB)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(sweep_start), .last_point_i(sweep_last_point),
    .num_stages_i(stage_count), .chop_en_i(chop_en), .stage_done_i(stage_done),
    .cfg_rd_o(cfg_rd_en), .cfg_addr_o(cfg_rd_addr), .cfg_data_i(cfg_rd_data),
    .modulus_o(src_modulus), .chop_phase_o(chop_phase), .busy_o(stage_busy),
    .tag_valid_o(tag_valid), .tag_o(tag), .done_o(sweep_done),
    .ev_stage_accept(ev_stage_accept), .ev_pass_flip(ev_pass_flip),
    .ev_point_end(ev_point_end));

  sweep_phase_gen u_phase (
    .modulus_i(src_modulus), .chop_phase_i(chop_phase), .phase_o(src_phase));

  // R6: pass 0 drives phase zero, and a phase never exceeds the modulus
  p_phase_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stage_busy && !chop_phase |-> src_phase == '0);
  p_phase_le_mod_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stage_busy |-> src_phase <= src_modulus);
  // R9: a point ends either in a new read or in the end of the sweep
  p_point_end_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_point_end |=> cfg_rd_en || sweep_done);
  // R3: stages are accepted only while busy
  p_accept_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stage_accept |-> stage_busy);
endmodule

// File: tb/sweep_sequencer_test.sv
module sweep_sequencer_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [3:0]  reg_wr_addr = '0;
  logic [15:0] reg_wr_data = '0;
  logic        sweep_start = 1'b0;
  logic [11:0] sweep_last_point = '0;
  logic [2:0]  stage_count = '0;
  logic        cfg_rd_en;
  logic [11:0] cfg_rd_addr;
  logic [95:0] cfg_rd_data = '0;
  logic [11:0] src_modulus, src_phase;
  logic        chop_phase, stage_busy;
  logic        stage_done = 1'b0;
  logic        tag_valid;
  logic [15:0] tag;
  logic        sweep_done;

  sweep_sequencer uut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
    .reg_wr_data(reg_wr_data), .sweep_start(sweep_start), .sweep_last_point(sweep_last_point),
    .stage_count(stage_count), .cfg_rd_en(cfg_rd_en), .cfg_rd_addr(cfg_rd_addr),
    .cfg_rd_data(cfg_rd_data), .src_modulus(src_modulus), .src_phase(src_phase),
    .chop_phase(chop_phase), .stage_busy(stage_busy), .stage_done(stage_done),
    .tag_valid(tag_valid), .tag(tag), .sweep_done(sweep_done));

  int checks = 0;
  int errors = 0;
  bit model_chop = 0;
  bit exp_active = 0, exp_need_load = 0, seen_done = 0, stray = 0;
  int exp_point = 0, exp_stage = 0, exp_phase = 0, exp_stages = 1, exp_last = 0;
  bit exp_chop = 0;
  int tag_cnt = 0;
  int dly = 0;

  function automatic logic [11:0] bm(int a);
    return 12'((a * 2897 + 345) ^ (a * 8));
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // configuration memory: one cycle read latency, modulus in bits [11:0]
  initial forever begin
    @(posedge clk);
    if (cfg_rd_en)
      cfg_rd_data <= {bm(int'(cfg_rd_addr)) ^ 12'hA5A, 72'h0, bm(int'(cfg_rd_addr))};
  end

  // monitor and stage responder
  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if (tag_valid) begin
        tag_cnt++;
        if (!exp_active) chk(0, "R3", "tag while no stage expected", int'(tag), 0);
        else begin
          logic [15:0] et;
          bit last_one;
          et = {exp_stage[2:0], exp_point[11:0], exp_phase[0]};
          chk(tag == et, "R4 R5 R8", "tag", int'(tag), int'(et));
          last_one = (exp_stage == exp_stages - 1) && (exp_phase == 1 || !exp_chop)
                     && (exp_point == exp_last);
          chk(sweep_done == last_one, "R9", "done with tag", int'(sweep_done), int'(last_one));
          if (exp_stage < exp_stages - 1) exp_stage++;
          else if (exp_chop && exp_phase == 0) begin exp_phase = 1; exp_stage = 0; end
          else if (exp_point == exp_last) begin exp_active = 0; seen_done = 1; end
          else begin exp_point++; exp_need_load = 1; end
        end
      end else if (sweep_done) chk(0, "R9", "done without tag", 1, 0);
      if (cfg_rd_en) begin
        chk(exp_need_load, "R9", "unexpected read", 1, int'(exp_need_load));
        chk(int'(cfg_rd_addr) == exp_point, "R2", "read address", int'(cfg_rd_addr), exp_point);
        exp_need_load = 0;
        exp_chop = model_chop;
        exp_stage = 0;
        exp_phase = 0;
      end
      stage_done = 1'b0;
      if (stage_busy) begin
        if (dly == 0) begin
          logic [11:0] m;
          m = bm(exp_point);
          chk(src_modulus == m, "R6", "modulus", int'(src_modulus), int'(m));
          chk(int'(src_phase) == (exp_phase == 1 ? int'(m) / 2 : 0), "R6 R7", "phase",
              int'(src_phase), exp_phase == 1 ? int'(m) / 2 : 0);
          chk(int'(chop_phase) == exp_phase, "R5", "pass bit", int'(chop_phase), exp_phase);
          stage_done = 1'b1;
          dly = $urandom_range(0, 2);
        end else dly--;
      end else if (stray) stage_done = 1'b1;
    end
  end

  task automatic write_reg(logic [3:0] a, logic [15:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
    @(posedge clk);
    if (a == 4'd6) model_chop = d[11];
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic run_sweep(int last, int stages, bit noise, int exp_tags);
    int guard = 0;
    @(negedge clk);
    sweep_last_point = 12'(last);
    stage_count = 3'(stages);
    exp_last = last;
    exp_stages = (stages == 0) ? 1 : stages;
    exp_point = 0; exp_need_load = 1; exp_active = 1; seen_done = 0; tag_cnt = 0;
    sweep_start = 1'b1;
    @(negedge clk);
    sweep_start = 1'b0;
    while (!seen_done && guard < 20000) begin
      if (noise) begin
        case ($urandom % 10)
          0: write_reg(4'd6, 16'($urandom));
          1: write_reg(4'($urandom_range(7, 15)), 16'hFFFF);
          2: begin sweep_start = 1'b1; @(negedge clk); sweep_start = 1'b0; end
          default: @(negedge clk);
        endcase
      end else @(negedge clk);
      guard++;
    end
    chk(seen_done, "R9", "sweep finished", int'(seen_done), 1);
    if (exp_tags >= 0) chk(tag_cnt == exp_tags, "R5 R7", "tag count", tag_cnt, exp_tags);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!stage_busy && !cfg_rd_en, "R9", "idle after done", int'(stage_busy), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!cfg_rd_en && !stage_busy && !tag_valid && !sweep_done, "R10", "idle outputs", 0, 0);
    chk(!chop_phase && src_phase == 0, "R10", "pass bit and phase", int'(src_phase), 0);

    write_reg(4'd6, 16'h0000);
    run_sweep(2, 3, 0, 9);                  // R7 single pass
    write_reg(4'd6, 16'h0800);
    run_sweep(1, 7, 0, 28);                 // R5 double pass, seven stages
    write_reg(4'd6, 16'hF7FF);              // R1 bit 11 clear, all others set
    run_sweep(0, 0, 0, 1);                  // R3 zero counts as one stage
    write_reg(4'd6, 16'h0800);
    write_reg(4'd5, 16'h0000);              // R1 other addresses do not clear it
    write_reg(4'd7, 16'h0000);
    run_sweep(0, 1, 0, 2);
    run_sweep(4, 2, 0, 20);                 // R5 enable held across a sweep

    tag_cnt = 0;
    stray = 1'b1;                           // R3 stage_done while idle
    repeat (6) @(negedge clk);
    stray = 1'b0;
    @(negedge clk);
    chk(tag_cnt == 0 && !stage_busy, "R3", "stray stage_done ignored", tag_cnt, 0);

    for (int k = 0; k < 10; k++)            // R8 R9 random writes and starts mid-sweep
      run_sweep($urandom_range(0, 5), $urandom_range(0, 7), 1, -1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule